// File: doc/BRIEF.md
# Dual Half-Bridge Gate Sequencer

This block is the digital core that sequences the four gate-enable signals of two half-bridge legs, A and B. Each leg has a high-side command and a low-side command. A single shared disable input, active high, forces every gate signal low. Within a leg the low-side command wins over the high-side command, so the two switches of one leg can never be asked to conduct together.

Every gate turn-on waits for a programmable number of clock cycles, called the dead time. Every turn-off takes effect without that wait. As a result, the partner switch is always off before its opposite turns on. A leg whose high-side command stays high works as a single-input complementary leg: the low-side command alone chooses which switch conducts.

All commands arrive on synchronous logic pins. They pass through a two-stage synchronizer, and the gate outputs are registered. A parameter mask marks each command pin as wired or unconnected. An unconnected pin reads as logic high, which is the level a pull-up would give it.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While the synchronized disable is high, all four gate outputs are low, whatever the other commands are. A rise of `dis_i` clears the outputs by the third rising clock edge, counting the edge that first captures it.
- R2: With disable low, each leg's outputs follow its own commands once the sync and dead-time latency has passed.
- R3: In a leg whose low-side command is high, the low-side gate is on and the high-side gate is off, whatever the high-side command is.
- R4: In a leg whose low-side command is low, the high-side gate equals the high-side command. With both commands low, both gates are off. With the high-side command held high, the low-side command alone selects the conducting switch.
- R5: A gate turn-on is first visible after the (D+4)th rising edge, where D is `dead_cycles_i` and the count includes the edge that captures the command. It is not visible after the (D+3)th edge.
- R6: A gate turn-off is visible after the third rising edge, counting the capturing edge, and is not yet visible after the second.
- R7: If a request disappears during its dead-time count, the gate stays low. A new request then waits the full D+4 edges again.
- R8: The two gates of one leg are never high in the same cycle. With D = 0, a swap of the conducting switch leaves both gates low for at least one cycle.
- R9: Parameter bits `HI_WIRED[i]`, `LO_WIRED[i]` (i = 0 for leg A, 1 for leg B) and `DIS_WIRED` set to 0 make that command read as high. An unconnected disable therefore holds all gates low.
- R10: A change of leg B's commands leaves leg A's gates unchanged, and the reverse holds too.
- R11: While reset is high, and after it until commands propagate, all gate outputs are low. The synchronizer stages reset to the high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dis_i | input | 1 | Shared disable, high forces all gates low |
| a_hi_i | input | 1 | Leg A high-side command |
| a_lo_i | input | 1 | Leg A low-side command |
| b_hi_i | input | 1 | Leg B high-side command |
| b_lo_i | input | 1 | Leg B low-side command |
| dead_cycles_i | input | DT_W | Dead time D in clock cycles |
| a_hi_o | output | 1 | Leg A high-side gate |
| a_lo_o | output | 1 | Leg A low-side gate |
| b_hi_o | output | 1 | Leg B high-side gate |
| b_lo_o | output | 1 | Leg B low-side gate |

## Verification
The bench builds three copies that share one set of stimulus. The first copy uses the default masks, with every pin wired. The second sets `HI_WIRED = 2'b01`, which makes leg B a complementary leg driven by its low-side command alone. The third sets `DIS_WIRED = 0`, so its gates must stay low no matter what the bench drives. With `DT_W = 8`, dead times of 0, 3 and 5 are exercised. This lets the bench count the exact turn-on and turn-off edges and check the one-cycle gap at zero dead time.

// File: rtl/hb_pkg.sv
package hb_pkg;

    localparam int NUM_LEGS = 2;

    typedef struct packed {
        logic hi;
        logic lo;
    } hb_pair_t;

    typedef enum logic [1:0] {
        DT_IDLE  = 2'd0,
        DT_COUNT = 2'd1,
        DT_ON    = 2'd2
    } dt_state_e;

    // Low side wins; disable removes both requests.
    function automatic hb_pair_t hb_resolve(hb_pair_t cmd, logic dis);
        hb_pair_t r;
        r.lo = cmd.lo & ~dis;
        r.hi = cmd.hi & ~cmd.lo & ~dis;
        return r;
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int       W       = 5,
    parameter logic     RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= {W{RST_VAL}};
            stage2_q <= {W{RST_VAL}};
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime
    import hb_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_i,
    input  logic            block_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            on_o
);
    dt_state_e       st_q;
    logic [DT_W-1:0] cnt_q;
    logic            on_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= DT_IDLE;
            cnt_q <= '0;
            on_q  <= 1'b0;
        end else begin
            case (st_q)
                DT_IDLE: begin
                    on_q <= 1'b0;
                    if (req_i) begin
                        st_q  <= DT_COUNT;
                        cnt_q <= dead_i;
                    end
                end
                DT_COUNT: begin
                    if (!req_i) begin
                        st_q  <= DT_IDLE;
                        on_q  <= 1'b0;
                    end else if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (!block_i) begin
                        st_q <= DT_ON;
                        on_q <= 1'b1;
                    end
                end
                DT_ON: begin
                    if (!req_i) begin
                        st_q <= DT_IDLE;
                        on_q <= 1'b0;
                    end
                end
                default: begin
                    st_q <= DT_IDLE;
                    on_q <= 1'b0;
                end
            endcase
        end
    end

    assign on_o = on_q;
endmodule

// File: rtl/hb_leg.sv
module hb_leg
    import hb_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  hb_pair_t        cmd_i,
    input  logic            dis_i,
    input  logic [DT_W-1:0] dead_i,
    output hb_pair_t        req_o,
    output hb_pair_t        gate_o
);
    hb_pair_t req;
    logic     hi_on;
    logic     lo_on;

    assign req   = hb_resolve(cmd_i, dis_i);
    assign req_o = req;

    hb_deadtime #(.DT_W(DT_W)) u_hi (
        .clk(clk), .rst(rst), .req_i(req.hi), .block_i(lo_on),
        .dead_i(dead_i), .on_o(hi_on)
    );

    hb_deadtime #(.DT_W(DT_W)) u_lo (
        .clk(clk), .rst(rst), .req_i(req.lo), .block_i(hi_on),
        .dead_i(dead_i), .on_o(lo_on)
    );

    assign gate_o.hi = hi_on;
    assign gate_o.lo = lo_on;
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
    import hb_pkg::*;
#(
    parameter int         DT_W      = 8,
    parameter logic [1:0] HI_WIRED  = 2'b11,
    parameter logic [1:0] LO_WIRED  = 2'b11,
    parameter logic       DIS_WIRED = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dis_i,
    input  logic            a_hi_i,
    input  logic            a_lo_i,
    input  logic            b_hi_i,
    input  logic            b_lo_i,
    input  logic [DT_W-1:0] dead_cycles_i,
    output logic            a_hi_o,
    output logic            a_lo_o,
    output logic            b_hi_o,
    output logic            b_lo_o
);
    localparam int SYNC_W = 2 * NUM_LEGS + 1;

    logic [NUM_LEGS-1:0] pin_hi;
    logic [NUM_LEGS-1:0] pin_lo;
    logic [NUM_LEGS-1:0] raw_hi;
    logic [NUM_LEGS-1:0] raw_lo;
    logic                raw_dis;
    logic [SYNC_W-1:0]   sync_q;
    logic [NUM_LEGS-1:0] hi_s;
    logic [NUM_LEGS-1:0] lo_s;
    logic                dis_s;
    logic [NUM_LEGS-1:0] req_hi;
    logic [NUM_LEGS-1:0] req_lo;
    logic [NUM_LEGS-1:0] gate_hi;
    logic [NUM_LEGS-1:0] gate_lo;

    assign pin_hi = {b_hi_i, a_hi_i};
    assign pin_lo = {b_lo_i, a_lo_i};

    genvar gi;
    generate
        for (gi = 0; gi < NUM_LEGS; gi++) begin : g_tie
            if (HI_WIRED[gi]) begin : g_hi_w
                assign raw_hi[gi] = pin_hi[gi];
            end else begin : g_hi_t
                assign raw_hi[gi] = 1'b1;
            end
            if (LO_WIRED[gi]) begin : g_lo_w
                assign raw_lo[gi] = pin_lo[gi];
            end else begin : g_lo_t
                assign raw_lo[gi] = 1'b1;
            end
        end
        if (DIS_WIRED) begin : g_dis_w
            assign raw_dis = dis_i;
        end else begin : g_dis_t
            assign raw_dis = 1'b1;
        end
    endgenerate

    hb_sync #(.W(SYNC_W), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst),
        .d_i({raw_dis, raw_hi, raw_lo}),
        .q_o(sync_q)
    );

    assign dis_s = sync_q[SYNC_W-1];
    assign hi_s  = sync_q[2*NUM_LEGS-1:NUM_LEGS];
    assign lo_s  = sync_q[NUM_LEGS-1:0];

    generate
        for (gi = 0; gi < NUM_LEGS; gi++) begin : g_leg
            hb_pair_t cmd;
            hb_pair_t req;
            hb_pair_t gate;
            assign cmd.hi = hi_s[gi];
            assign cmd.lo = lo_s[gi];
            hb_leg #(.DT_W(DT_W)) u_leg (
                .clk(clk), .rst(rst), .cmd_i(cmd), .dis_i(dis_s),
                .dead_i(dead_cycles_i), .req_o(req), .gate_o(gate)
            );
            assign req_hi[gi]  = req.hi;
            assign req_lo[gi]  = req.lo;
            assign gate_hi[gi] = gate.hi;
            assign gate_lo[gi] = gate.lo;
        end
    endgenerate

    assign a_hi_o = gate_hi[0];
    assign a_lo_o = gate_lo[0];
    assign b_hi_o = gate_hi[1];
    assign b_lo_o = gate_lo[1];
endmodule

// File: rtl/hb_gate_ctrl_chk.sv
module hb_gate_ctrl_chk #(
    parameter int DT_W = 8,
    parameter int NL   = 2
) (
    input logic            clk,
    input logic            rst,
    input logic [DT_W-1:0] dead,
    input logic            dis_s,
    input logic [NL-1:0]   lo_s,
    input logic [NL-1:0]   req_hi,
    input logic [NL-1:0]   req_lo,
    input logic [NL-1:0]   gate_hi,
    input logic [NL-1:0]   gate_lo
);
    localparam int RUN_W = DT_W + 2;

    a_r1_disable_clears: assert property (@(posedge clk) disable iff (rst)
        dis_s |=> (gate_hi == '0 && gate_lo == '0));

    genvar gi;
    generate
        for (gi = 0; gi < NL; gi++) begin : g_chk
            logic [RUN_W-1:0] run_hi;
            logic [RUN_W-1:0] run_lo;

            always_ff @(posedge clk) begin
                if (rst) begin
                    run_hi <= '0;
                    run_lo <= '0;
                end else begin
                    run_hi <= !req_hi[gi] ? '0 : (&run_hi ? run_hi : run_hi + 1'b1);
                    run_lo <= !req_lo[gi] ? '0 : (&run_lo ? run_lo : run_lo + 1'b1);
                end
            end

            a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
                !(gate_hi[gi] && gate_lo[gi]));

            a_r3_low_priority: assert property (@(posedge clk) disable iff (rst)
                lo_s[gi] |=> !gate_hi[gi]);

            a_r6_hi_off_prompt: assert property (@(posedge clk) disable iff (rst)
                !req_hi[gi] |=> !gate_hi[gi]);

            a_r6_lo_off_prompt: assert property (@(posedge clk) disable iff (rst)
                !req_lo[gi] |=> !gate_lo[gi]);

            a_r5_hi_waits: assert property (@(posedge clk) disable iff (rst)
                $rose(gate_hi[gi]) |-> (run_hi > RUN_W'(dead)));

            a_r5_lo_waits: assert property (@(posedge clk) disable iff (rst)
                $rose(gate_lo[gi]) |-> (run_lo > RUN_W'(dead)));
        end
    endgenerate
endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk #(.DT_W(DT_W), .NL(hb_pkg::NUM_LEGS)) u_chk (
    .clk(clk), .rst(rst), .dead(dead_cycles_i), .dis_s(dis_s), .lo_s(lo_s),
    .req_hi(req_hi), .req_lo(req_lo), .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/sim_hb_gate_ctrl.sv
module sim_hb_gate_ctrl;
    localparam int DT_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dis = 1'b1;
    logic ah = 1'b0, al = 1'b0, bh = 1'b0, bl = 1'b0;
    logic [DT_W-1:0] dead = 8'd3;
    logic [3:0] o0, o1, o2;   // {a_hi, a_lo, b_hi, b_lo}
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hb_gate_ctrl #(.DT_W(DT_W)) u0 (
        .clk(clk), .rst(rst), .dis_i(dis), .a_hi_i(ah), .a_lo_i(al),
        .b_hi_i(bh), .b_lo_i(bl), .dead_cycles_i(dead),
        .a_hi_o(o0[3]), .a_lo_o(o0[2]), .b_hi_o(o0[1]), .b_lo_o(o0[0]));

    hb_gate_ctrl #(.DT_W(DT_W), .HI_WIRED(2'b01)) u1 (
        .clk(clk), .rst(rst), .dis_i(dis), .a_hi_i(ah), .a_lo_i(al),
        .b_hi_i(bh), .b_lo_i(bl), .dead_cycles_i(dead),
        .a_hi_o(o1[3]), .a_lo_o(o1[2]), .b_hi_o(o1[1]), .b_lo_o(o1[0]));

    hb_gate_ctrl #(.DT_W(DT_W), .DIS_WIRED(1'b0)) u2 (
        .clk(clk), .rst(rst), .dis_i(dis), .a_hi_i(ah), .a_lo_i(al),
        .b_hi_i(bh), .b_lo_i(bl), .dead_cycles_i(dead),
        .a_hi_o(o2[3]), .a_lo_o(o2[2]), .b_hi_o(o2[1]), .b_lo_o(o2[0]));

    // stimulus {dis, a_hi, a_lo, b_hi, b_lo}, expected u0 {ah, al, bh, bl}
    localparam logic [8:0] VEC [8] = '{
        {5'b0_10_01, 4'b10_01},
        {5'b0_11_10, 4'b01_10},
        {5'b0_00_00, 4'b00_00},
        {5'b0_01_11, 4'b01_01},
        {5'b1_10_10, 4'b00_00},
        {5'b0_10_10, 4'b10_10},
        {5'b1_01_01, 4'b00_00},
        {5'b0_00_11, 4'b00_01}
    };

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // R8: no leg ever has both gates high, checked every cycle
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if ((o0[3] & o0[2]) | (o0[1] & o0[0]) | (o1[3] & o1[2]) | (o1[1] & o1[0])) begin
                fails++;
                $display("FAIL R8 overlap: u0 %b u1 %b expected no leg pair high", o0, o1);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        finish_run();
    end

    initial begin
        // R11: reset state
        wait_n(4);
        chk("R11 reset u0", o0, 4'b0000);
        chk("R11 reset u1", o1, 4'b0000);
        @(negedge clk) rst = 1'b0;
        wait_n(12);
        chk("R11 after reset, dis high", o0, 4'b0000);

        // table walk: R1 R2 R3 R4 R9
        for (int i = 0; i < 8; i++) begin
            logic [4:0] s;
            logic [3:0] e1;
            s = VEC[i][8:4];
            {dis, ah, al, bh, bl} = s;
            wait_n(14);
            chk("R1/R2/R3/R4 table u0", o0, VEC[i][3:0]);
            // leg B of u1 has its high command unconnected (reads high)
            e1 = {VEC[i][3:2], ~s[0] & ~s[4], s[0] & ~s[4]};
            chk("R9 table u1 complementary leg B", o1, e1);
            chk("R9 table u2 unconnected disable", o2, 4'b0000);
        end

        // R5: turn-on timing, D = 5
        dis = 1'b0; ah = 1'b0; al = 1'b0; bh = 1'b0; bl = 1'b0;
        wait_n(10);
        dead = 8'd5;
        wait_n(2);
        ah = 1'b1;
        wait_n(8);
        chk("R5 a_hi still off at D+3", o0, 4'b0000);
        wait_n(1);
        chk("R5 a_hi on at D+4", o0, 4'b1000);

        // R6: turn-off timing
        wait_n(3);
        ah = 1'b0;
        wait_n(2);
        chk("R6 a_hi still on after 2 edges", o0, 4'b1000);
        wait_n(1);
        chk("R6 a_hi off after 3 edges", o0, 4'b0000);

        // R7: request dropped mid-count, then full restart
        wait_n(4);
        al = 1'b1;
        wait_n(5);
        al = 1'b0;
        wait_n(12);
        chk("R7 aborted request stays off", o0, 4'b0000);
        al = 1'b1;
        wait_n(8);
        chk("R7 restart not early at D+3", o0, 4'b0000);
        wait_n(1);
        chk("R7 restart on at D+4", o0, 4'b0100);

        // R10: leg A steady while leg B toggles
        for (int k = 0; k < 3; k++) begin
            bh = 1'b1;
            wait_n(5);
            chk("R10 leg A unchanged while B moves", {o0[3:2], 2'b00}, 4'b0100);
            bh = 1'b0;
            wait_n(5);
            chk("R10 leg A unchanged while B moves", {o0[3:2], 2'b00}, 4'b0100);
        end

        // R8: zero dead time swap on u1 leg B (complementary)
        al = 1'b0;
        dead = 8'd0;
        bl = 1'b0;
        wait_n(10);
        chk("R8 u1 leg B high side on", {2'b00, o1[1:0]}, 4'b0010);
        bl = 1'b1;
        wait_n(2);
        chk("R8 u1 high still on", {2'b00, o1[1:0]}, 4'b0010);
        wait_n(1);
        chk("R8 u1 one-cycle gap both off", {2'b00, o1[1:0]}, 4'b0000);
        wait_n(1);
        chk("R8 u1 low side on after gap", {2'b00, o1[1:0]}, 4'b0001);

        // R1: disable rise latency
        ah = 1'b1; bl = 1'b0; bh = 1'b1;
        wait_n(8);
        chk("R2 u0 both highs on", o0, 4'b1010);
        dis = 1'b1;
        wait_n(2);
        chk("R1 not cleared before 3rd edge", o0, 4'b1010);
        wait_n(1);
        chk("R1 cleared at 3rd edge", o0, 4'b0000);
        chk("R9 u2 stays off", o2, 4'b0000);

        wait_n(4);
        finish_run();
    end
endmodule